// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor that executes one instruction per rising clock edge. It supports word loads and stores, five register-to-register operations (add, subtract, AND, OR, signed set-less-than), an equality branch and an absolute jump. Every instruction is fetched, decoded, executed and written back within a single cycle. Instruction storage, data storage and a 32-entry register file all sit inside the block.

While reset is held, a simple loader port fills either memory one word at a time. Memory contents are kept through reset. When reset is released, execution starts at address 0. A register debug read port and a data-memory peek port let the surrounding logic observe architectural state without disturbing it.

The ALU operation is selected in two levels. The main decoder turns the opcode into a set of datapath control lines and a 2-bit operation class. A second decoder combines that class with the funct field to choose the 3-bit ALU operation.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the PC and all 32 registers read as zero. A loader write (`ld_we`=1) stores `ld_data` at word `ld_addr` of data memory when `ld_dmem`=1, or of instruction memory when `ld_dmem`=0. Memory contents survive reset.
- R2: An instruction that neither branches nor jumps advances the PC by 4. The PC is a byte address, and the instruction word is taken from word PC>>2.
- R3: A load (opcode 100011) writes data-memory word ((rs + sign-extended imm[15:0]) >> 2), taken modulo the memory depth, into register rt (bits 20:16). Base register is rs (bits 25:21).
- R4: A store (opcode 101011) writes register rt into data-memory word ((rs + sign-extended imm) >> 2) and writes no register.
- R5: An R-type instruction (opcode 000000) with funct 100000 writes rs+rt, and with funct 100010 writes rs−rt, into register rd (bits 15:11).
- R6: R-type funct 100100 writes rs AND rt, and funct 100101 writes rs OR rt, into rd.
- R7: R-type funct 101010 writes 1 into rd when rs < rt as signed 32-bit values, and 0 otherwise.
- R8: A branch (opcode 000100) with rs equal to rt sets the PC to PC+4+(sign-extended imm<<2). When rs differs from rt, the PC becomes PC+4.
- R9: A jump (opcode 000010) sets the PC to {PC[31:28], imm26, 2'b00}, where imm26 is bits 25:0.
- R10: Register 0 always reads as zero. A write to register 0 leaves it zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset; also enables the loader |
| ld_we | input | 1 | Loader write strobe, honoured only during reset |
| ld_dmem | input | 1 | Loader target: 1 selects data memory, 0 selects instruction memory |
| ld_addr | input | LAW | Loader word index |
| ld_data | input | 32 | Loader write data |
| dbg_raddr | input | 5 | Register debug read index |
| dbg_rdata | output | 32 | Register debug read data (combinational) |
| peek_addr | input | DAW | Data-memory peek word index |
| peek_data | output | 32 | Data-memory peek data (combinational) |
| pc | output | 32 | Current program counter |

## Verification
The bench builds the core with its default 64-word instruction memory and 64-word data memory. With these sizes a 19-instruction program fits, and it reaches every opcode, every funct code, a negative load offset, a register-0 write, a skipped forward branch, a forward jump and a branch back onto itself that parks the PC. The signed comparison is exercised by a negative loaded value in both operand orders. A second reset in mid-run confirms that memory is retained while registers and the PC clear.

// File: rtl/sc_core_pkg.sv
`timescale 1ns/1ps
package sc_core_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JUMP  = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_class_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic       dst_rd;
        logic       src_imm;
        logic       wb_mem;
        logic       reg_we;
        logic       mem_re;
        logic       mem_we;
        logic       branch;
        logic       jump;
        alu_class_e alu_class;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_op_e    alu_op
);

    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                ctl.dst_rd    = 1'b1;
                ctl.reg_we    = 1'b1;
                ctl.alu_class = CLS_FUNCT;
            end
            OPC_LOAD: begin
                ctl.src_imm   = 1'b1;
                ctl.wb_mem    = 1'b1;
                ctl.reg_we    = 1'b1;
                ctl.mem_re    = 1'b1;
                ctl.alu_class = CLS_ADD;
            end
            OPC_STORE: begin
                ctl.src_imm   = 1'b1;
                ctl.mem_we    = 1'b1;
                ctl.alu_class = CLS_ADD;
            end
            OPC_BEQ: begin
                ctl.branch    = 1'b1;
                ctl.alu_class = CLS_SUB;
            end
            OPC_JUMP: begin
                ctl.jump      = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    always_comb begin
        unique case (ctl.alu_class)
            CLS_ADD: alu_op = ALU_ADD;
            CLS_SUB: alu_op = ALU_SUB;
            default: begin
                unique case (funct)
                    FN_ADD:  alu_op = ALU_ADD;
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: alu_op = ALU_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
)(
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

    always_comb begin
        if (op == ALU_SLT) begin
            AST_SLT_SINGLE_BIT: assert (y[W-1:1] == '0); // R7
        end
        if (op == ALU_SUB && a == b) begin
            AST_SUB_EQUAL_ZERO: assert (zero); // R8
        end
    end

endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] rf_q [NREG];
    logic [W-1:0] rf_d [NREG];

    always_comb begin
        rf_d = rf_q;
        if (we && wa != '0) begin
            rf_d[wa] = wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q <= '{default: '0};
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd1 = rf_q[ra1];
    assign rd2 = rf_q[ra2];
    assign rd3 = rf_q[ra3];

    AST_ZERO_REG_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0) |=> (rf_q[0] == '0)); // R10

endmodule

// File: rtl/sc_wordmem.sv
`timescale 1ns/1ps
module sc_wordmem #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [W-1:0]  rdata [NRD]
);

    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end

endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_we,
    input  logic            ld_dmem,
    input  logic [LAW-1:0]  ld_addr,
    input  logic [31:0]     ld_data,
    input  logic [4:0]      dbg_raddr,
    output logic [31:0]     dbg_rdata,
    input  logic [DAW-1:0]  peek_addr,
    output logic [31:0]     peek_data,
    output logic [31:0]     pc
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_q, st_d;

    logic [XLEN-1:0] instr;
    logic [5:0]      f_op;
    logic [RIDX-1:0] f_rs, f_rt, f_rd;
    logic [15:0]     f_imm;
    logic [25:0]     f_jaddr;
    logic [5:0]      f_funct;
    logic [XLEN-1:0] imm_sx;

    ctrl_t           ctl;
    alu_op_e         alu_op;

    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] load_raw, load_data, wb_data;
    logic [RIDX-1:0] wb_idx;

    logic [XLEN-1:0] pc_plus4, br_tgt, jmp_tgt;

    logic [IAW-1:0]  i_ra [1];
    logic [XLEN-1:0] i_rd [1];
    logic            i_we;

    logic [DAW-1:0]  d_ra [2];
    logic [XLEN-1:0] d_rd [2];
    logic            d_we;
    logic [DAW-1:0]  d_wa;
    logic [XLEN-1:0] d_wd;

    // ---------------- fetch ----------------
    assign i_ra[0] = st_q.pc[IAW+1:2];
    assign i_we    = !rst_n && ld_we && !ld_dmem;

    sc_wordmem #(.DEPTH(IMEM_WORDS), .W(XLEN), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (i_we),
        .waddr (ld_addr[IAW-1:0]),
        .wdata (ld_data),
        .raddr (i_ra),
        .rdata (i_rd)
    );

    assign instr   = i_rd[0];
    assign f_op    = instr[31:26];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_imm   = instr[15:0];
    assign f_funct = instr[5:0];
    assign f_jaddr = instr[25:0];
    assign imm_sx  = {{(XLEN-16){f_imm[15]}}, f_imm};

    // ---------------- decode ----------------
    sc_decode u_dec (
        .opcode (f_op),
        .funct  (f_funct),
        .ctl    (ctl),
        .alu_op (alu_op)
    );

    // ---------------- registers ----------------
    sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .ra3   (dbg_raddr),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rd3   (dbg_rdata),
        .we    (ctl.reg_we),
        .wa    (wb_idx),
        .wd    (wb_data)
    );

    // ---------------- execute ----------------
    assign alu_b = ctl.src_imm ? imm_sx : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // ---------------- data memory ----------------
    assign d_ra[0] = alu_y[DAW+1:2];
    assign d_ra[1] = peek_addr;
    assign d_we    = rst_n ? ctl.mem_we : (ld_we && ld_dmem);
    assign d_wa    = rst_n ? alu_y[DAW+1:2] : ld_addr[DAW-1:0];
    assign d_wd    = rst_n ? rt_val : ld_data;

    sc_wordmem #(.DEPTH(DMEM_WORDS), .W(XLEN), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (d_we),
        .waddr (d_wa),
        .wdata (d_wd),
        .raddr (d_ra),
        .rdata (d_rd)
    );

    assign load_raw  = d_rd[0];
    assign peek_data = d_rd[1];
    assign load_data = ctl.mem_re ? load_raw : '0;

    // ---------------- write-back ----------------
    assign wb_idx  = ctl.dst_rd ? f_rd : f_rt;
    assign wb_data = ctl.wb_mem ? load_data : alu_y;

    // ---------------- next PC ----------------
    assign pc_plus4 = st_q.pc + 32'd4;
    assign br_tgt   = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign jmp_tgt  = {st_q.pc[31:28], f_jaddr, 2'b00};

    always_comb begin
        st_d = st_q;
        if (ctl.jump) begin
            st_d.pc = jmp_tgt;
        end else if (ctl.branch && alu_zero) begin
            st_d.pc = br_tgt;
        end else begin
            st_d.pc = pc_plus4;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;

    AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pc[1:0] == 2'b00); // R2
    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.branch && !ctl.jump) |=> (st_q.pc == $past(st_q.pc) + 32'd4)); // R2
    AST_BEQ_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.branch && rs_val == rt_val) |=> (st_q.pc == $past(br_tgt))); // R8
    AST_JUMP_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.jump |=> (st_q.pc[27:0] == {$past(instr[25:0]), 2'b00})); // R9
    AST_STORE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mem_we && !ctl.reg_we) |=> $stable(dbg_raddr) |-> $stable(dbg_rdata)); // R4

endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;

    localparam int IMEM_WORDS = 64;
    localparam int DMEM_WORDS = 64;
    localparam int DAW = $clog2(DMEM_WORDS);
    localparam int LAW = 6;

    function automatic logic [31:0] r_ins(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] i_ins(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] j_ins(input logic [25:0] tgt);
        return {6'b000010, tgt};
    endfunction

    localparam logic [5:0] LW = 6'b100011;
    localparam logic [5:0] SW = 6'b101011;
    localparam logic [5:0] BQ = 6'b000100;
    localparam int NPROG = 19;

    localparam logic [31:0] PROG [NPROG] = '{
        i_ins(LW, 5'd0, 5'd1, 16'd0),          // 0  r1 = 5
        i_ins(LW, 5'd0, 5'd2, 16'd4),          // 1  r2 = -3
        r_ins(5'd1, 5'd2, 5'd3, 6'b100000),    // 2  r3 = 2
        r_ins(5'd1, 5'd2, 5'd4, 6'b100010),    // 3  r4 = 8
        r_ins(5'd2, 5'd4, 5'd5, 6'b100100),    // 4  r5 = 8
        r_ins(5'd1, 5'd4, 5'd6, 6'b100101),    // 5  r6 = 13
        r_ins(5'd2, 5'd1, 5'd7, 6'b101010),    // 6  r7 = 1
        r_ins(5'd1, 5'd2, 5'd8, 6'b101010),    // 7  r8 = 0
        r_ins(5'd1, 5'd1, 5'd0, 6'b100000),    // 8  r0 write ignored
        i_ins(SW, 5'd0, 5'd6, 16'd8),          // 9  dmem[2] = 13
        i_ins(BQ, 5'd1, 5'd2, 16'd5),          // 10 not taken
        i_ins(BQ, 5'd3, 5'd3, 16'd1),          // 11 taken -> 13
        r_ins(5'd1, 5'd1, 5'd9, 6'b100000),    // 12 skipped
        j_ins(26'd16),                         // 13 jump -> 16
        r_ins(5'd1, 5'd1, 5'd10, 6'b100000),   // 14 skipped
        r_ins(5'd1, 5'd1, 5'd10, 6'b100000),   // 15 skipped
        i_ins(LW, 5'd0, 5'd11, 16'd8),         // 16 r11 = 13
        i_ins(LW, 5'd4, 5'd12, 16'hFFFC),      // 17 r12 = -3
        i_ins(BQ, 5'd0, 5'd0, 16'hFFFF)        // 18 branch onto itself
    };

    localparam int NEXP = 13;
    localparam logic [31:0] EXP_REG [NEXP] = '{
        32'd0, 32'd5, 32'hFFFF_FFFD, 32'd2, 32'd8, 32'd8, 32'd13,
        32'd1, 32'd0, 32'd0, 32'd0, 32'd13, 32'hFFFF_FFFD
    };
    localparam string EXP_TAG [NEXP] = '{
        "R10", "R3", "R3", "R5", "R5", "R6", "R6",
        "R7", "R7", "R8", "R9", "R4", "R3"
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ld_we = 1'b0;
    logic           ld_dmem = 1'b0;
    logic [LAW-1:0] ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [4:0]     dbg_raddr = '0;
    logic [31:0]    dbg_rdata;
    logic [DAW-1:0] peek_addr = '0;
    logic [31:0]    peek_data;
    logic [31:0]    pc;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sc_core #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_sc_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we     (ld_we),
        .ld_dmem   (ld_dmem),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .dbg_raddr (dbg_raddr),
        .dbg_rdata (dbg_rdata),
        .peek_addr (peek_addr),
        .peek_data (peek_data),
        .pc        (pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load_word(input logic to_dmem, input int idx, input logic [31:0] val);
        ld_we   = 1'b1;
        ld_dmem = to_dmem;
        ld_addr = LAW'(idx);
        ld_data = val;
        @(posedge clk);
        @(negedge clk);
        ld_we   = 1'b0;
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] val);
        dbg_raddr = 5'(idx);
        #0.5;
        val = dbg_rdata;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        // R1: reset state and loader
        chk("R1", pc, 32'd0);
        for (int i = 0; i < NPROG; i++) load_word(1'b0, i, PROG[i]);
        load_word(1'b1, 0, 32'd5);
        load_word(1'b1, 1, 32'hFFFF_FFFD);
        load_word(1'b1, 2, 32'd7);
        read_reg(1, v);
        chk("R1", v, 32'd0);
        peek_addr = DAW'(2);
        #0.5;
        chk("R1", peek_data, 32'd7);
        chk("R1", pc, 32'd0);

        rst_n = 1'b1;
        step(1);
        chk("R2", pc, 32'd4);
        read_reg(1, v);
        chk("R3", v, 32'd5);
        step(10);
        chk("R8", pc, 32'd44);   // not-taken branch at word 10
        peek_addr = DAW'(2);
        #0.5;
        chk("R4", peek_data, 32'd13);
        step(1);
        chk("R8", pc, 32'd52);   // taken branch skips word 12
        step(1);
        chk("R9", pc, 32'd64);   // jump to word 16
        step(20);
        chk("R8", pc, 32'd72);   // branch onto itself parks the PC

        for (int i = 0; i < NEXP; i++) begin
            read_reg(i, v);
            chk(EXP_TAG[i], v, EXP_REG[i]);
        end
        peek_addr = DAW'(0);
        #0.5;
        chk("R4", peek_data, 32'd5);

        // R1: mid-run reset clears PC and registers but keeps memory
        @(negedge clk);
        rst_n = 1'b0;
        #0.5;
        chk("R1", pc, 32'd0);
        read_reg(6, v);
        chk("R1", v, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);
        read_reg(1, v);
        chk("R1", v, 32'd5);
        chk("R2", pc, 32'd4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule